// File: doc/BRIEF.md
# Two-Stage Pipeline Code Recombiner

This block forms the final output word of a two-stage pipelined converter. Stage one delivers a 6-bit coarse code and stage two delivers a 4-bit fine code for the same analog sample, but one sample period later. The block holds each coarse code until its matching fine code arrives. It then weights the fine code by the reciprocal of the inter-stage gain and adds it to the coarse code. With the correct weight, the coarse stage's quantization and comparator error drop out of the sum, and only the fine stage's error remains.

The weight is a register loaded through a write port, not a fixed shift. Its reset value is 1/32, which matches the nominal gain of 32. Calibration can rewrite it to cancel a gain error of several percent. Each fine strobe produces one registered output sample, one cycle later.

Top module: `recomb_filter`

## Requirements
- R1: After reset, out_vld is 0 and out_data is 0. The held coarse code is 0, so a fine strobe before any coarse strobe pairs with coarse value 0. The weight is 0x0400.
- R2: out_data = coarse * 2^15 + fine * weight, as a 22-bit two's-complement value with 15 fractional bits. Here coarse is the 6-bit code read as two's complement, fine is the 4-bit code read as two's complement, and weight is the 16-bit value read as unsigned with 15 fractional bits.
- R3: No overflow or wrap occurs anywhere in the input range. This includes coarse -32 or 31, fine -8 or 7, and weight 0xFFFF.
- R4: A fine strobe pairs with the coarse code captured at the most recent coarse strobe in an earlier cycle. A coarse strobe in the same cycle as a fine strobe belongs to the next sample.
- R5: out_vld is high in exactly the cycle after each fine strobe and low in every other cycle.
- R6: out_data keeps its value in every cycle that follows a cycle without a fine strobe. This holds even when the weight is written in that cycle.
- R7: A weight write takes effect from the next fine strobe. A fine strobe in the same cycle as the write still uses the old weight.
- R8: With the reset weight, one step of the fine code counts 1/32 of one step of the coarse code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coarse_vld | input | 1 | Stage-one code strobe |
| coarse_code | input | 6 | Stage-one code, two's complement |
| fine_vld | input | 1 | Stage-two code strobe |
| fine_code | input | 4 | Stage-two code, two's complement |
| coef_we | input | 1 | Weight write enable |
| coef_wdata | input | 16 | New weight, unsigned, 15 fractional bits |
| out_vld | output | 1 | Output sample strobe |
| out_data | output | 22 | Recombined sample, two's complement, 15 fractional bits |

## Verification
A wrong held coarse code shows up in the very next output sample as an error of whole coarse steps (multiples of 2^15). A stale or corrupted weight shows up in the next output sample as an error that scales with the fine code, so it stays hidden while the fine code is zero. For that reason the stimulus uses nonzero fine codes of both signs. A pairing fault shows up only when coarse and fine strobes overlap, so a back-to-back stream is driven as well as isolated samples.

// File: rtl/recomb_pkg.sv
package recomb_pkg;
   typedef enum logic [0:0] {
      MUL_NATIVE   = 1'b0,
      MUL_SHIFTADD = 1'b1
   } mul_style_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/recomb_align.sv
module recomb_align #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic [W-1:0] din,
   output logic [W-1:0] held
);
   always_ff @(posedge clk) begin
      if (!rst_n)   held <= '0;
      else if (cap) held <= din;
   end
endmodule

// File: rtl/recomb_coef.sv
module recomb_coef #(
   parameter int           W   = 16,
   parameter logic [W-1:0] RST = 16'h0400
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] coef
);
   always_ff @(posedge clk) begin
      if (!rst_n)  coef <= RST;
      else if (we) coef <= wdata;
   end
endmodule

// File: rtl/recomb_mac.sv
module recomb_mac
   import recomb_pkg::*;
#(
   parameter int         CRS_W     = 6,
   parameter int         FIN_W     = 4,
   parameter int         COEF_W    = 16,
   parameter int         COEF_FRAC = 15,
   parameter int         OUT_W     = 22,
   parameter mul_style_e STYLE     = MUL_NATIVE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [CRS_W-1:0]  crs,
   input  logic [FIN_W-1:0]  fin,
   input  logic [COEF_W-1:0] coef,
   output logic              vld,
   output logic [OUT_W-1:0]  sum
);
   localparam int PROD_W = FIN_W + COEF_W + 1;
   localparam int CEXT   = OUT_W - CRS_W - COEF_FRAC;
   localparam int PEXT   = OUT_W - PROD_W;

   logic signed [PROD_W-1:0] fin_x, coef_x, prod;
   logic signed [OUT_W-1:0]  crs_x, prod_x, sum_d;

   assign fin_x  = {{(PROD_W-FIN_W){fin[FIN_W-1]}}, fin};
   assign coef_x = {{(PROD_W-COEF_W){1'b0}}, coef};

   generate
      if (STYLE == MUL_NATIVE) begin : g_native
         assign prod = fin_x * coef_x;
      end else begin : g_shiftadd
         always_comb begin
            prod = '0;
            for (int i = 0; i < COEF_W; i++) begin
               if (coef[i]) prod = prod + (fin_x <<< i);
            end
         end
      end
   endgenerate

   assign crs_x  = {{CEXT{crs[CRS_W-1]}}, crs, {COEF_FRAC{1'b0}}};
   assign prod_x = {{PEXT{prod[PROD_W-1]}}, prod};
   assign sum_d  = crs_x + prod_x;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= 1'b0;
         sum <= '0;
      end else begin
         vld <= fire;
         if (fire) sum <= sum_d;
      end
   end
endmodule

// File: rtl/recomb_filter.sv
module recomb_filter
   import recomb_pkg::*;
#(
   parameter int                CRS_W     = 6,
   parameter int                FIN_W     = 4,
   parameter int                COEF_W    = 16,
   parameter int                COEF_FRAC = 15,
   parameter logic [COEF_W-1:0] COEF_RST  = 16'h0400,
   parameter mul_style_e        STYLE     = MUL_NATIVE,
   localparam int               OUT_W     = imax(CRS_W + COEF_FRAC, FIN_W + COEF_W + 1) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              coarse_vld,
   input  logic [CRS_W-1:0]  coarse_code,
   input  logic              fine_vld,
   input  logic [FIN_W-1:0]  fine_code,
   input  logic              coef_we,
   input  logic [COEF_W-1:0] coef_wdata,
   output logic              out_vld,
   output logic [OUT_W-1:0]  out_data
);
   generate
      if (COEF_FRAC >= COEF_W) begin : g_bad_frac
         $error("COEF_FRAC must be below COEF_W");
      end
      if (CRS_W < 2 || FIN_W < 2) begin : g_bad_width
         $error("code widths must be at least 2");
      end
   endgenerate

   logic [CRS_W-1:0]  held_w;
   logic [COEF_W-1:0] coef_w;

   recomb_align #(.W(CRS_W)) u_align (
      .clk(clk), .rst_n(rst_n), .cap(coarse_vld), .din(coarse_code), .held(held_w)
   );

   recomb_coef #(.W(COEF_W), .RST(COEF_RST)) u_coef (
      .clk(clk), .rst_n(rst_n), .we(coef_we), .wdata(coef_wdata), .coef(coef_w)
   );

   recomb_mac #(
      .CRS_W(CRS_W), .FIN_W(FIN_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC),
      .OUT_W(OUT_W), .STYLE(STYLE)
   ) u_mac (
      .clk(clk), .rst_n(rst_n), .fire(fine_vld), .crs(held_w), .fin(fine_code),
      .coef(coef_w), .vld(out_vld), .sum(out_data)
   );
endmodule

// File: rtl/recomb_filter_chk.sv
module recomb_filter_chk #(
   parameter int CRS_W     = 6,
   parameter int FIN_W     = 4,
   parameter int COEF_W    = 16,
   parameter int COEF_FRAC = 15,
   parameter int OUT_W     = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              coarse_vld,
   input logic [CRS_W-1:0]  coarse_code,
   input logic              fine_vld,
   input logic [FIN_W-1:0]  fine_code,
   input logic              coef_we,
   input logic [COEF_W-1:0] coef_wdata,
   input logic              out_vld,
   input logic [OUT_W-1:0]  out_data,
   input logic [CRS_W-1:0]  held,
   input logic [COEF_W-1:0] coef
);
   logic signed [OUT_W-1:0] h_s, f_s, k_s, exp_now;
   assign h_s     = OUT_W'($signed(held));
   assign f_s     = OUT_W'($signed(fine_code));
   assign k_s     = OUT_W'({1'b0, coef});
   assign exp_now = (h_s <<< COEF_FRAC) + f_s * k_s;

   a_r5_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
      fine_vld |=> out_vld);
   a_r5_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !fine_vld |=> !out_vld);
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fine_vld |=> $stable(out_data));
   a_r7_coef_load: assert property (@(posedge clk) disable iff (!rst_n)
      coef_we |=> coef == $past(coef_wdata));
   a_r7_coef_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !coef_we |=> $stable(coef));
   a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
      coarse_vld |=> held == $past(coarse_code));
   a_r2_sum: assert property (@(posedge clk) disable iff (!rst_n)
      fine_vld |=> $signed(out_data) == $past(exp_now));
endmodule

bind recomb_filter recomb_filter_chk #(
   .CRS_W(CRS_W), .FIN_W(FIN_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .OUT_W(OUT_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .coarse_vld(coarse_vld), .coarse_code(coarse_code),
   .fine_vld(fine_vld), .fine_code(fine_code), .coef_we(coef_we),
   .coef_wdata(coef_wdata), .out_vld(out_vld), .out_data(out_data),
   .held(held_w), .coef(coef_w)
);

// File: tb/test_recomb_filter.sv
module test_recomb_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        coarse_vld = 1'b0;
   logic [5:0]  coarse_code = '0;
   logic        fine_vld = 1'b0;
   logic [3:0]  fine_code = '0;
   logic        coef_we = 1'b0;
   logic [15:0] coef_wdata = '0;
   logic        out_vld;
   logic [21:0] out_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   recomb_filter i_recomb_filter (
      .clk(clk), .rst_n(rst_n), .coarse_vld(coarse_vld), .coarse_code(coarse_code),
      .fine_vld(fine_vld), .fine_code(fine_code), .coef_we(coef_we),
      .coef_wdata(coef_wdata), .out_vld(out_vld), .out_data(out_data)
   );

   // coarse, fine, weight, expected = coarse*32768 + fine*weight (R2, R3, R8)
   localparam int V_C[8] = '{0, 31, -32, 5, -1, 31, -32, 10};
   localparam int V_F[8] = '{0, 7, -8, -1, 3, 7, -8, 4};
   localparam int V_K[8] = '{32'h0400, 32'h0400, 32'h0400, 32'h0435,
                             32'h03CF, 32'hFFFF, 32'hFFFF, 32'h8000};
   localparam int V_E[8] = '{0, 1022976, -1056768, 162763,
                             -29843, 1474553, -1572856, 458752};

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint outv();
      return longint'($signed(out_data));
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      longint last;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 out_vld after reset", out_vld, 0);
      chk("R1 out_data after reset", outv(), 0);

      // table walk: R2, R3, R8, R5, R6
      for (int i = 0; i < 8; i++) begin
         coef_we = 1'b1; coef_wdata = 16'(V_K[i]);
         @(negedge clk);
         coef_we = 1'b0; coarse_vld = 1'b1; coarse_code = 6'(V_C[i]);
         @(negedge clk);
         coarse_vld = 1'b0; fine_vld = 1'b1; fine_code = 4'(V_F[i]);
         @(negedge clk);
         fine_vld = 1'b0;
         chk($sformatf("R5 out_vld vec %0d", i), out_vld, 1);
         chk($sformatf("R2 R3 R8 sum vec %0d", i), outv(), V_E[i]);
         @(negedge clk);
         chk($sformatf("R5 pulse end vec %0d", i), out_vld, 0);
      end

      // R4: overlapping coarse and fine strobes
      coef_we = 1'b1; coef_wdata = 16'h0400;
      @(negedge clk);
      coef_we = 1'b0; coarse_vld = 1'b1; coarse_code = 6'd3;
      @(negedge clk);
      coarse_code = 6'd9; fine_vld = 1'b1; fine_code = 4'd2;
      @(negedge clk);
      chk("R4 pair with earlier coarse", outv(), 100352);
      coarse_vld = 1'b0; fine_code = 4'(-2);
      @(negedge clk);
      chk("R4 pair second sample", outv(), 292864);
      chk("R5 back-to-back vld", out_vld, 1);

      // R7: write in same cycle as fine strobe uses old weight
      coef_we = 1'b1; coef_wdata = 16'h0800; fine_code = 4'd1;
      @(negedge clk);
      chk("R7 old weight in write cycle", outv(), 295936);
      coef_we = 1'b0;
      @(negedge clk);
      chk("R7 new weight next sample", outv(), 296960);
      fine_vld = 1'b0;

      // R6: weight write without fine strobe leaves output alone
      @(negedge clk);
      last = outv();
      coef_we = 1'b1; coef_wdata = 16'h1000;
      @(negedge clk);
      coef_we = 1'b0;
      chk("R6 out_vld low on write only", out_vld, 0);
      chk("R6 out_data held on write", outv(), last);
      @(negedge clk);
      chk("R6 out_data held idle", outv(), last);

      // R1: reset restores held coarse 0 and weight 0x0400
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 out_data cleared", outv(), 0);
      fine_vld = 1'b1; fine_code = 4'(-3);
      @(negedge clk);
      chk("R1 held coarse is zero", outv(), -3072);
      fine_vld = 1'b0; coarse_vld = 1'b1; coarse_code = 6'd1;
      @(negedge clk);
      coarse_vld = 1'b0; fine_vld = 1'b1; fine_code = 4'd1;
      @(negedge clk);
      fine_vld = 1'b0;
      chk("R1 R8 reset weight 1/32", outv(), 33792);
      @(negedge clk);
      finish_run();
   end
endmodule